// File: doc/BRIEF.md
# Dual-Port Memory with Same-Address Contention Arbitration

This block is a synchronous true dual-port memory of `2**ADDR_W` words of `DATA_W` bits. Ports A and B each have an enable, a write strobe, an address, write data and registered read data. Either port can reach any word. The 8K x 8 configuration is built with `ADDR_W = 13`. The default is smaller so that elaboration stays light.

Each cycle the block checks whether both ports are enabled on the same word. When they are, it decides which port keeps the location. The other port gets a registered clash flag, and its writes are dropped for as long as the overlap lasts. The winner is the port that was already on that word in the previous cycle. When both ports arrive in the same cycle, port A wins. Reads on the losing port are still served.

A mode input, `arb_local`, selects where the clash flags come from:
- With `arb_local` high, the block arbitrates for itself and drives the flags.
- With `arb_local` low, the block keeps its own flags low and instead takes a clash input per port, which only suppresses that port's writes.

Several devices can therefore be placed side by side for a wider word. One device arbitrates and feeds its flags to the others.

Top module: `dpram_contend`

## Requirements
- R1: Storage is `2**ADDR_W` words of `DATA_W` bits, and both ports can write and read every word. Read data is registered: an enabled port's `rdata` shows the word at its address one clock after the edge, and `rdata` holds its value while the port is disabled.
- R2: With `arb_local`=1, a cycle in which both ports are enabled on equal addresses raises exactly one clash flag (`a_clash_o` or `b_clash_o`) after that clock edge. The flag stays high for every following cycle in which the overlap continues.
- R3: After a clock edge at which the ports are not both enabled on equal addresses, both clash flags are low.
- R4: When an overlap begins, the winner is the port that was enabled on that same address in the previous cycle; the other port gets the flag. For example, if B was at an address first and A joins, A loses.
- R5: When both ports begin the overlap in the same cycle, port A wins and `b_clash_o` is raised.
- R6: In local arbitration mode, the losing port's write is discarded in every cycle of the overlap, including its first cycle.
- R7: In the first cycle after the overlap ends, a write still presented by the former loser is stored.
- R8: The losing port's reads are served during an overlap. A read returns the word stored before the clock edge. A write made at that edge by the other port is seen by the next read.
- R9: With `arb_local`=0, both clash outputs stay low. A high `a_clash_i` or `b_clash_i` discards only that port's write; reads and the other port are unaffected.
- R10: With `arb_local`=0 and no clash input high, two writes to the same word in one cycle leave port A's data stored.
- R11: A synchronous reset clears both clash flags and the arbitration history, and no write is stored while reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arb_local | input | 1 | 1: arbitrate internally and drive the clash flags; 0: take the clash inputs |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A write strobe (valid with `a_en`) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| a_clash_i | input | 1 | Port A external clash, blocks A writes when `arb_local`=0 |
| a_clash_o | output | 1 | Port A lost arbitration (registered) |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B write strobe (valid with `b_en`) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| b_clash_i | input | 1 | Port B external clash, blocks B writes when `arb_local`=0 |
| b_clash_o | output | 1 | Port B lost arbitration (registered) |

## Verification
The bench builds the block with `ADDR_W = 4` and `DATA_W = 8`, so sixteen words cover the whole array. With so few words, both ports can be steered onto a shared address within a few cycles. This makes it quick to reach:
- overlaps where either port arrives first;
- overlaps where both arrive together;
- release by an address change and release by an enable drop;
- a reset taken in the middle of an overlap;
- external-clash operation in both directions.

At this size every word can also be preloaded and read back from either port.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    // Which port, if any, lost the current same-address overlap
    typedef enum logic [1:0] {
        LOSE_NONE = 2'd0,
        LOSE_A    = 2'd1,
        LOSE_B    = 2'd2
    } dpc_lose_e;

endpackage

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arb_local,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_clash_i,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_clash_i,
    output logic              a_wr_en,
    output logic              b_wr_en,
    output logic              a_clash_o,
    output logic              b_clash_o
);

    typedef struct packed {
        dpc_lose_e         lose;
        logic              a_en;
        logic              b_en;
        logic [ADDR_W-1:0] a_addr;
        logic [ADDR_W-1:0] b_addr;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    same_loc;
    logic    a_early;
    logic    b_early;
    logic    a_blk;
    logic    b_blk;

    always_comb begin
        st_d        = st_q;
        // one cycle of request history decides who arrived first
        st_d.a_en   = a_en;
        st_d.b_en   = b_en;
        st_d.a_addr = a_addr;
        st_d.b_addr = b_addr;

        same_loc = a_en && b_en && (a_addr == b_addr);
        a_early  = st_q.a_en && (st_q.a_addr == a_addr);
        b_early  = st_q.b_en && (st_q.b_addr == b_addr);

        if (!arb_local || !same_loc) begin
            st_d.lose = LOSE_NONE;
        end else if (st_q.lose == LOSE_NONE) begin
            // fresh overlap: B wins only if it alone was already there
            st_d.lose = (b_early && !a_early) ? LOSE_A : LOSE_B;
        end

        a_blk   = arb_local ? (st_d.lose == LOSE_A) : a_clash_i;
        b_blk   = arb_local ? (st_d.lose == LOSE_B) : b_clash_i;
        a_wr_en = a_en && a_wr && !a_blk && !rst;
        b_wr_en = b_en && b_wr && !b_blk && !rst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lose   <= LOSE_NONE;
            st_q.a_en   <= 1'b0;
            st_q.b_en   <= 1'b0;
            st_q.a_addr <= '0;
            st_q.b_addr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_clash_o = (st_q.lose == LOSE_A);
    assign b_clash_o = (st_q.lose == LOSE_B);

    // R3: no overlap this cycle means no flag after the edge
    assert_release_R3: assert property (@(posedge clk) disable iff (rst)
        !(a_en && b_en && (a_addr == b_addr)) |=> (!a_clash_o && !b_clash_o));

    // R2: an overlap in local mode yields exactly one flag
    assert_one_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (arb_local && a_en && b_en && (a_addr == b_addr))
        |=> $countones({a_clash_o, b_clash_o}) == 1);

    // R11: reset leaves both flags low
    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (!a_clash_o && !b_clash_o));

endmodule

// File: rtl/dpc_mem_array.sv
module dpc_mem_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic              a_wr_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_wr_en,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int NPORT = 2;

    logic [DATA_W-1:0] mem_q [DEPTH];

    logic [NPORT-1:0]  rd_en;
    logic [ADDR_W-1:0] rd_addr [NPORT];
    logic [DATA_W-1:0] rd_d    [NPORT];
    logic [DATA_W-1:0] rd_q    [NPORT];

    assign rd_en      = {b_en, a_en};
    assign rd_addr[0] = a_addr;
    assign rd_addr[1] = b_addr;

    // A is written last so it takes the word when both write together
    always_ff @(posedge clk) begin
        if (b_wr_en) begin
            mem_q[b_addr] <= b_wdata;
        end
        if (a_wr_en) begin
            mem_q[a_addr] <= a_wdata;
        end
    end

    // read-first ports: old contents are returned on a same-edge write
    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        always_comb begin
            rd_d[p] = rd_q[p];
            if (rd_en[p]) begin
                rd_d[p] = mem_q[rd_addr[p]];
            end
        end

        always_ff @(posedge clk) begin
            rd_q[p] <= rd_d[p];
        end
    end

    assign a_rdata = rd_q[0];
    assign b_rdata = rd_q[1];

endmodule

// File: rtl/dpram_contend.sv
module dpram_contend #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arb_local,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              a_clash_i,
    output logic              a_clash_o,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    input  logic              b_clash_i,
    output logic              b_clash_o
);

    logic a_wr_en;
    logic b_wr_en;

    dpc_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .arb_local (arb_local),
        .a_en      (a_en),
        .a_wr      (a_wr),
        .a_addr    (a_addr),
        .a_clash_i (a_clash_i),
        .b_en      (b_en),
        .b_wr      (b_wr),
        .b_addr    (b_addr),
        .b_clash_i (b_clash_i),
        .a_wr_en   (a_wr_en),
        .b_wr_en   (b_wr_en),
        .a_clash_o (a_clash_o),
        .b_clash_o (b_clash_o)
    );

    dpc_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .a_en    (a_en),
        .a_wr_en (a_wr_en),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .a_rdata (a_rdata),
        .b_en    (b_en),
        .b_wr_en (b_wr_en),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .b_rdata (b_rdata)
    );

    // R6: a port already flagged and still overlapping never writes
    assert_loser_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (arb_local && a_en && b_en && (a_addr == b_addr) && a_clash_o)
        |-> !a_wr_en);

    // R9: external clash input suppresses that port's write
    assert_ext_block_R9: assert property (@(posedge clk) disable iff (rst)
        (!arb_local && b_clash_i) |-> !b_wr_en);

    // R9: flags stay low in external mode
    assert_ext_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !arb_local |=> (!a_clash_o && !b_clash_o));

endmodule

// File: tb/sim_dpram_contend.sv
module sim_dpram_contend;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arb_local = 1'b1;
    logic a_en = 1'b0, a_wr = 1'b0, a_clash_i = 1'b0;
    logic b_en = 1'b0, b_wr = 1'b0, b_clash_i = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_clash_o, b_clash_o;

    always #2 clk = ~clk;

    dpram_contend #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .arb_local(arb_local),
        .a_en(a_en), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_clash_i(a_clash_i), .a_clash_o(a_clash_o),
        .b_en(b_en), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_clash_i(b_clash_i), .b_clash_o(b_clash_o)
    );

    // behavioural reference state
    logic [DW-1:0] m_mem [WORDS];
    bit m_la, m_lb, m_pa_en, m_pb_en, m_va, m_vb;
    int m_pa_addr, m_pb_addr;
    logic [DW-1:0] m_ra, m_rb;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit ms, input bit rs,
                        input bit ae, input bit aw, input int aa, input int ad,
                        input bit be, input bit bw, input int ba, input int bd,
                        input bit aci, input bit bci);
        bit ovl, ea, eb, nla, nlb, blka, blkb;
        arb_local = ms; rst = rs;
        a_en = ae; a_wr = aw; a_addr = AW'(aa); a_wdata = DW'(ad);
        b_en = be; b_wr = bw; b_addr = AW'(ba); b_wdata = DW'(bd);
        a_clash_i = aci; b_clash_i = bci;
        if (rs) begin
            m_la = 0; m_lb = 0; m_pa_en = 0; m_pb_en = 0; m_pa_addr = 0; m_pb_addr = 0;
        end else begin
            ovl = ae && be && (aa == ba);
            nla = m_la; nlb = m_lb;
            if (!ms || !ovl) begin
                nla = 0; nlb = 0;
            end else if (!m_la && !m_lb) begin
                ea = m_pa_en && (m_pa_addr == aa);
                eb = m_pb_en && (m_pb_addr == ba);
                if (eb && !ea) nla = 1; else nlb = 1;
            end
            blka = ms ? nla : aci;
            blkb = ms ? nlb : bci;
            if (ae) begin m_ra = m_mem[aa]; m_va = 1; end
            if (be) begin m_rb = m_mem[ba]; m_vb = 1; end
            if (be && bw && !blkb) m_mem[ba] = DW'(bd);
            if (ae && aw && !blka) m_mem[aa] = DW'(ad);
            m_la = nla; m_lb = nlb;
            m_pa_en = ae; m_pb_en = be; m_pa_addr = aa; m_pb_addr = ba;
        end
        @(posedge clk);
        @(negedge clk);
        cmp(tag, "a_clash_o", int'(a_clash_o), int'(m_la));
        cmp(tag, "b_clash_o", int'(b_clash_o), int'(m_lb));
        if (m_va) cmp(tag, "a_rdata", int'(a_rdata), int'(m_ra));
        if (m_vb) cmp(tag, "b_rdata", int'(b_rdata), int'(m_rb));
    endtask

    task automatic idle(input string tag);
        step(tag, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        // R11: reset state
        step("R11", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R11", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1: preload every word through A, read all back through B
        for (int i = 0; i < WORDS; i++) step("R1", 1, 0, 1, 1, i, 'h30 + i, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < WORDS; i++) step("R1", 1, 0, 0, 0, 0, 0, 1, 0, i, 0, 0, 0);
        idle("R1");
        // R4 R6 R2: A holds word 5, B joins writing and loses
        step("R4", 1, 0, 1, 0, 5, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) step("R6", 1, 0, 1, 0, 5, 0, 1, 1, 5, 'hAA, 0, 0);
        // R7: A leaves, B's held write lands, flag drops
        step("R7", 1, 0, 0, 0, 0, 0, 1, 1, 5, 'hAA, 0, 0);
        step("R7", 1, 0, 1, 0, 5, 0, 1, 0, 5, 0, 0, 0);
        idle("R7");
        // R4: B first on word 9, A joins writing and loses
        step("R4", 1, 0, 0, 0, 0, 0, 1, 0, 9, 0, 0, 0);
        step("R4", 1, 0, 1, 1, 9, 'h55, 1, 0, 9, 0, 0, 0);
        step("R4", 1, 0, 1, 1, 9, 'h55, 1, 0, 9, 0, 0, 0);
        idle("R6");
        step("R6", 1, 0, 1, 0, 9, 0, 0, 0, 0, 0, 0, 0);
        // R5: simultaneous arrival on word 3
        step("R5", 1, 0, 1, 1, 3, 'h11, 1, 1, 3, 'h22, 0, 0);
        step("R5", 1, 0, 1, 1, 3, 'h11, 1, 1, 3, 'h22, 0, 0);
        idle("R5");
        step("R5", 1, 0, 1, 0, 3, 0, 1, 0, 4, 0, 0, 0);
        // R3: overlap released by an address change
        step("R3", 1, 0, 1, 0, 7, 0, 0, 0, 0, 0, 0, 0);
        step("R3", 1, 0, 1, 0, 7, 0, 1, 0, 7, 0, 0, 0);
        step("R3", 1, 0, 1, 0, 8, 0, 1, 0, 7, 0, 0, 0);
        idle("R3");
        // R8: loser reads old word while winner writes, new word next
        step("R8", 1, 0, 1, 0, 2, 0, 0, 0, 0, 0, 0, 0);
        step("R8", 1, 0, 1, 1, 2, 'h77, 1, 0, 2, 0, 0, 0);
        step("R8", 1, 0, 0, 0, 0, 0, 1, 0, 2, 0, 0, 0);
        idle("R8");
        // R11: reset during an overlap clears the flag
        step("R11", 1, 0, 1, 0, 6, 0, 0, 0, 0, 0, 0, 0);
        step("R11", 1, 0, 1, 0, 6, 0, 1, 0, 6, 0, 0, 0);
        step("R11", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle("R11");
        // R10: external mode, both write word 4, A's data kept
        step("R10", 0, 0, 1, 1, 4, 'h44, 1, 1, 4, 'h66, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 0, 1, 0, 4, 0, 0, 0);
        // R9: external clash inputs block writes on the flagged port only
        step("R9", 0, 0, 1, 1, 12, 'hC1, 1, 1, 6, 'hB6, 0, 1);
        step("R9", 0, 0, 1, 0, 12, 0, 1, 0, 6, 0, 0, 1);
        step("R9", 0, 0, 1, 1, 13, 'hD1, 1, 1, 14, 'hE1, 1, 0);
        step("R9", 0, 0, 1, 0, 13, 0, 1, 0, 14, 0, 0, 0);
        step("R9", 0, 0, 1, 0, 11, 0, 1, 0, 11, 0, 0, 0);
        idle("R9");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule